// File: doc/BRIEF.md
# Condition Code and Branch Evaluator

This block keeps the processor's 8-bit condition code register and decides conditional branches. Each cycle it can update the register from information about the result of an arithmetic or logic operation: the two operands, the result, whether the operation was a subtraction, and the carries out of the low nibble and out of the top bit. Negative, zero and two's-complement overflow are derived here from the operands and the result. The carries are passed straight through as the half-carry and carry flags.

Every flag has its own write enable, so an instruction that leaves a flag untouched keeps the old value. A separate load port writes all six flags at once. It serves register transfers and the restore of saved state after an interrupt. The two top bits of the register always read as one.

The branch side is purely combinational. It reads the stored flags, a 4-bit condition selector, the address of the branch instruction and an 8-bit signed offset. It produces a taken bit and the target address: the instruction address plus two plus the sign-extended offset.

Top module: `cc_branch_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the register becomes 0xD0. That value has bits 7 and 6 at one, the interrupt mask (bit 4) at one and all other flags at zero.
- R2: Bits 7 and 6 of `ccr_out` read as one at all times, including after a load of all zeros.
- R3: The register layout from bit 5 down to bit 0 is half-carry, interrupt mask, negative, zero, overflow, carry. When its enable is set, the negative flag takes bit 7 of `alu_res`, and the zero flag becomes 1 exactly when `alu_res` is 0.
- R4: When their enables are set, the half-carry flag takes `carry_nib` (the carry out of bit 3) and the carry flag takes `carry_hi` (the carry out of bit 7).
- R5: When its enable is set, the overflow flag is 1 exactly when the signed result of `alu_a + alu_b` (`alu_sub`=0) or `alu_a - alu_b` (`alu_sub`=1) lies outside -128..127.
- R6: Bit k of `flag_we` enables register bit k for k = 0..5. A flag whose enable is low keeps its value. The interrupt mask, when enabled, takes `mask_in`.
- R7: When `load_en` is high, bits 5..0 take `load_flags` at the next edge. This overrides all per-flag enables.
- R8: Simple tests on `cond_sel`: 0 is always taken and 1 never. 4/5 are taken on carry clear/set, 6/7 on zero clear/set, 8/9 on overflow clear/set, and 10/11 on negative clear/set.
- R9: Unsigned tests: code 2 (higher) is taken when carry OR zero is 0, and code 3 (lower or same) when carry OR zero is 1.
- R10: Signed tests, with s = negative XOR overflow: code 12 is taken when s=0 and code 13 when s=1. Code 14 is taken when zero OR s is 0, and code 15 when zero OR s is 1.
- R11: `br_target` equals `pc_in` + 2 + the sign-extended `rel_off`, modulo 2^16. This gives a reach of -126..+129 bytes from the instruction address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_a | input | 8 | First ALU operand |
| alu_b | input | 8 | Second ALU operand |
| alu_res | input | 8 | ALU result |
| alu_sub | input | 1 | 1 when the operation was a subtraction |
| carry_hi | input | 1 | Carry (or borrow) out of bit 7 |
| carry_nib | input | 1 | Carry (or borrow) out of bit 3 |
| flag_we | input | 6 | Per-flag write enables, bit k for register bit k |
| mask_in | input | 1 | New interrupt mask value |
| load_en | input | 1 | Load all six flags from `load_flags` |
| load_flags | input | 6 | Flag values for a full load (bits 5..0) |
| cond_sel | input | 4 | Branch condition code |
| pc_in | input | 16 | Address of the branch instruction |
| rel_off | input | 8 | Signed branch offset |
| ccr_out | output | 8 | Condition code register |
| br_taken | output | 1 | Branch condition holds |
| br_target | output | 16 | Branch target address |

## Verification
A wrong stored flag appears on `ccr_out` one edge after the write that caused it. It also changes `br_taken` in the same cycle for every condition code that reads that flag. A flag that wrongly moves while its enable is low shows up right after the cycle in which the enable was low. The bench checks this by setting the register to all-ones with a load, then presenting zero-valued ALU information under a single enable. A swapped decode row or a flipped signed test shows only for particular flag combinations. All 64 flag patterns are therefore crossed with all 16 codes.

// File: rtl/ccb_pkg.sv
`timescale 1ns/1ps
package ccb_pkg;

    localparam int          FLAG_N    = 6;
    localparam int          CCR_W     = 8;
    localparam logic [7:0]  CCR_RESET = 8'hD0;

    // bit 5 down to bit 0
    typedef struct packed {
        logic h;
        logic i;
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    typedef enum logic [3:0] {
        BR_ALWAYS = 4'd0,
        BR_NEVER  = 4'd1,
        BR_HI     = 4'd2,
        BR_LS     = 4'd3,
        BR_CC     = 4'd4,
        BR_CS     = 4'd5,
        BR_NE     = 4'd6,
        BR_EQ     = 4'd7,
        BR_VC     = 4'd8,
        BR_VS     = 4'd9,
        BR_PL     = 4'd10,
        BR_MI     = 4'd11,
        BR_GE     = 4'd12,
        BR_LT     = 4'd13,
        BR_GT     = 4'd14,
        BR_LE     = 4'd15
    } cond_e;

    function automatic logic signed_less(flags_t f);
        return f.n ^ f.v;
    endfunction

    function automatic logic cond_true(cond_e sel, flags_t f);
        logic t;
        case (sel)
            BR_ALWAYS: t = 1'b1;
            BR_NEVER:  t = 1'b0;
            BR_HI:     t = ~(f.c | f.z);
            BR_LS:     t = f.c | f.z;
            BR_CC:     t = ~f.c;
            BR_CS:     t = f.c;
            BR_NE:     t = ~f.z;
            BR_EQ:     t = f.z;
            BR_VC:     t = ~f.v;
            BR_VS:     t = f.v;
            BR_PL:     t = ~f.n;
            BR_MI:     t = f.n;
            BR_GE:     t = ~signed_less(f);
            BR_LT:     t = signed_less(f);
            BR_GT:     t = ~(f.z | signed_less(f));
            default:   t = f.z | signed_less(f);
        endcase
        return t;
    endfunction

    function automatic logic [CCR_W-1:0] pack_ccr(flags_t f);
        return {2'b11, f};
    endfunction

endpackage

// File: rtl/ccb_flag_calc.sv
`timescale 1ns/1ps
module ccb_flag_calc
    import ccb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [DATA_W-1:0] res,
    input  logic              is_sub,
    input  logic              carry_hi,
    input  logic              carry_nib,
    output flags_t            alu_f
);
    localparam int MSB = DATA_W - 1;

    logic sign_a, sign_b_eff;

    always_comb begin
        sign_a     = op_a[MSB];
        // subtraction adds the complement of b, so its sign flips
        sign_b_eff = is_sub ? ~op_b[MSB] : op_b[MSB];
        alu_f.h    = carry_nib;
        alu_f.i    = 1'b0;
        alu_f.n    = res[MSB];
        alu_f.z    = ~|res;
        alu_f.v    = (sign_a == sign_b_eff) && (res[MSB] != sign_a);
        alu_f.c    = carry_hi;
    end

endmodule

// File: rtl/ccb_cond_reg.sv
`timescale 1ns/1ps
module ccb_cond_reg
    import ccb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  flags_t            alu_f,
    input  logic              mask_in,
    input  logic [FLAG_N-1:0] we,
    input  logic              load_en,
    input  flags_t            load_f,
    output flags_t            cur
);
    localparam logic [FLAG_N-1:0] RESET_FLAGS = CCR_RESET[FLAG_N-1:0];

    flags_t            src_f;
    logic [FLAG_N-1:0] src_v, ld_v, cur_q;

    always_comb begin
        src_f   = alu_f;
        src_f.i = mask_in;
        src_v   = src_f;
        ld_v    = load_f;
    end

    for (genvar k = 0; k < FLAG_N; k++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                cur_q[k] <= RESET_FLAGS[k];
            else if (load_en)
                cur_q[k] <= ld_v[k];
            else if (we[k])
                cur_q[k] <= src_v[k];
        end

        AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
            (!load_en && !we[k]) |=> $stable(cur_q[k]))
            else $error("flag %0d moved without enable", k); // R6
    end

    assign cur = flags_t'(cur_q);

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (cur_q == $past(ld_v)))
        else $error("load did not take effect"); // R7

    AST_RESET_VALUE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cur_q == RESET_FLAGS))
        else $error("reset value wrong"); // R1

endmodule

// File: rtl/ccb_branch_eval.sv
`timescale 1ns/1ps
module ccb_branch_eval
    import ccb_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  flags_t            f,
    input  cond_e             sel,
    input  logic [ADDR_W-1:0] pc,
    input  logic [DATA_W-1:0] off,
    output logic              taken,
    output logic [ADDR_W-1:0] target
);
    localparam int EXT_W = ADDR_W - DATA_W;
    localparam logic [ADDR_W-1:0] INSTR_LEN = ADDR_W'(2);

    logic [ADDR_W-1:0] off_ext;
    logic [ADDR_W-1:0] span;

    always_comb begin
        off_ext = {{EXT_W{off[DATA_W-1]}}, off};
        target  = pc + INSTR_LEN + off_ext;
        taken   = cond_true(sel, f);
        span    = target - pc;
    end

    AST_NEVER_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (sel == BR_NEVER) |-> !taken)
        else $error("never-code taken"); // R8

    AST_HI_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (sel == BR_HI && taken) |-> (!f.c && !f.z))
        else $error("higher taken with c or z set"); // R9

    AST_GT_NOT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (sel == BR_GT && taken) |-> !f.z)
        else $error("greater-than taken on zero"); // R10

    AST_TARGET_REACH: assert property (@(posedge clk) disable iff (rst)
        ($signed(span) >= -126) && ($signed(span) <= 129))
        else $error("target out of reach"); // R11

endmodule

// File: rtl/cc_branch_unit.sv
`timescale 1ns/1ps
module cc_branch_unit
    import ccb_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] alu_a,
    input  logic [DATA_W-1:0] alu_b,
    input  logic [DATA_W-1:0] alu_res,
    input  logic              alu_sub,
    input  logic              carry_hi,
    input  logic              carry_nib,
    input  logic [5:0]        flag_we,
    input  logic              mask_in,
    input  logic              load_en,
    input  logic [5:0]        load_flags,
    input  logic [3:0]        cond_sel,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DATA_W-1:0] rel_off,
    output logic [7:0]        ccr_out,
    output logic              br_taken,
    output logic [ADDR_W-1:0] br_target
);
    flags_t alu_f, cur_f;

    ccb_flag_calc #(.DATA_W(DATA_W)) flag_calc_i (
        .op_a      (alu_a),
        .op_b      (alu_b),
        .res       (alu_res),
        .is_sub    (alu_sub),
        .carry_hi  (carry_hi),
        .carry_nib (carry_nib),
        .alu_f     (alu_f)
    );

    ccb_cond_reg cond_reg_i (
        .clk     (clk),
        .rst     (rst),
        .alu_f   (alu_f),
        .mask_in (mask_in),
        .we      (flag_we),
        .load_en (load_en),
        .load_f  (flags_t'(load_flags)),
        .cur     (cur_f)
    );

    ccb_branch_eval #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) branch_eval_i (
        .clk    (clk),
        .rst    (rst),
        .f      (cur_f),
        .sel    (cond_e'(cond_sel)),
        .pc     (pc_in),
        .off    (rel_off),
        .taken  (br_taken),
        .target (br_target)
    );

    assign ccr_out = pack_ccr(cur_f);

    AST_TOP_ONES: assert property (@(posedge clk) disable iff (rst)
        ccr_out[7:6] == 2'b11)
        else $error("top bits not one"); // R2

endmodule

// File: tb/cc_branch_unit_tb_top.sv
`timescale 1ns/1ps
module cc_branch_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  alu_a = '0, alu_b = '0, alu_res = '0;
    logic        alu_sub = 1'b0, carry_hi = 1'b0, carry_nib = 1'b0;
    logic [5:0]  flag_we = '0;
    logic        mask_in = 1'b0, load_en = 1'b0;
    logic [5:0]  load_flags = '0;
    logic [3:0]  cond_sel = '0;
    logic [15:0] pc_in = '0;
    logic [7:0]  rel_off = '0;
    logic [7:0]  ccr_out;
    logic        br_taken;
    logic [15:0] br_target;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    cc_branch_unit dut_i (
        .clk(clk), .rst(rst), .alu_a(alu_a), .alu_b(alu_b), .alu_res(alu_res),
        .alu_sub(alu_sub), .carry_hi(carry_hi), .carry_nib(carry_nib),
        .flag_we(flag_we), .mask_in(mask_in), .load_en(load_en),
        .load_flags(load_flags), .cond_sel(cond_sel), .pc_in(pc_in),
        .rel_off(rel_off), .ccr_out(ccr_out), .br_taken(br_taken),
        .br_target(br_target)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load_reg(input logic [5:0] v);
        load_en = 1'b1; load_flags = v; flag_we = '0;
        step();
        load_en = 1'b0;
    endtask

    function automatic bit exp_taken(input int sel, input logic [5:0] f);
        bit n, z, v, c, s;
        n = f[3]; z = f[2]; v = f[1]; c = f[0]; s = n ^ v;
        case (sel)
            0: return 1'b1;
            1: return 1'b0;
            2: return !(c | z);
            3: return c | z;
            4: return !c;
            5: return c;
            6: return !z;
            7: return z;
            8: return !v;
            9: return v;
            10: return !n;
            11: return n;
            12: return !s;
            13: return s;
            14: return !(z | s);
            default: return z | s;
        endcase
    endfunction

    initial begin
        int pcs [5];
        pcs = '{16'h0000, 16'h1280, 16'hFFFE, 16'h00FF, 16'h7F80};

        @(negedge clk);
        step();
        check(ccr_out == 8'hD0, "R1 reset value", ccr_out, 8'hD0);
        rst = 1'b0;

        // ALU flag sweep: all enables except the mask
        flag_we = 6'b101111;
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < 256; a += 3) begin
                for (int b = 0; b < 256; b += 3) begin
                    int r, sv;
                    bit c, h, v;
                    if (s == 1) begin
                        r  = (a - b) & 255;
                        c  = a < b;
                        h  = (a & 15) < (b & 15);
                        sv = $signed(8'(a)) - $signed(8'(b));
                    end else begin
                        r  = (a + b) & 255;
                        c  = (a + b) > 255;
                        h  = ((a & 15) + (b & 15)) > 15;
                        sv = $signed(8'(a)) + $signed(8'(b));
                    end
                    v = (sv > 127) || (sv < -128);
                    alu_a = 8'(a); alu_b = 8'(b); alu_res = 8'(r);
                    alu_sub = s[0]; carry_hi = c; carry_nib = h;
                    step();
                    check(ccr_out[3] == r[7] && ccr_out[2] == (r == 0),
                          "R3 N/Z", ccr_out, {r[7], (r == 0), 2'b00});
                    check(ccr_out[5] == h && ccr_out[0] == c,
                          "R4 H/C", ccr_out, {h, 4'b0, c});
                    check(ccr_out[1] == v, "R5 V", ccr_out[1], v);
                    check(ccr_out[7:6] == 2'b11 && ccr_out[4] == 1'b1,
                          "R6 mask held", ccr_out, 8'hD0);
                end
            end
        end

        // per-flag enables: only bit k may clear
        for (int k = 0; k < 6; k++) begin
            load_reg(6'h3F);
            alu_a = 8'h00; alu_b = 8'h00; alu_res = 8'h01; alu_sub = 1'b0;
            carry_hi = 1'b0; carry_nib = 1'b0; mask_in = 1'b0;
            flag_we = 6'(1 << k);
            step();
            flag_we = '0;
            check(ccr_out == (8'hFF & ~8'(1 << k)), "R6 single enable",
                  ccr_out, 8'hFF & ~8'(1 << k));
        end
        load_reg(6'h00);
        mask_in = 1'b1; flag_we = 6'b010000;
        step();
        flag_we = '0; mask_in = 1'b0;
        check(ccr_out == 8'hD0, "R6 mask write", ccr_out, 8'hD0);

        // load priority and fixed top bits
        alu_res = 8'h80; alu_a = 8'h7F; alu_b = 8'h01;
        carry_hi = 1'b1; carry_nib = 1'b1;
        load_en = 1'b1; load_flags = 6'h15; flag_we = 6'h3F;
        step();
        load_en = 1'b0; flag_we = '0;
        check(ccr_out == 8'hD5, "R7 load over enables", ccr_out, 8'hD5);
        load_reg(6'h00);
        check(ccr_out == 8'hC0, "R2 top bits after zero load", ccr_out, 8'hC0);
        load_reg(6'h3F);
        check(ccr_out == 8'hFF, "R7 all-ones load", ccr_out, 8'hFF);

        // branch decode: every flag pattern against every code
        for (int f = 0; f < 64; f++) begin
            load_reg(6'(f));
            for (int sel = 0; sel < 16; sel++) begin
                bit e;
                cond_sel = 4'(sel);
                step();
                e = exp_taken(sel, 6'(f));
                if (sel == 2 || sel == 3)
                    check(br_taken == e, "R9 unsigned test", br_taken, e);
                else if (sel >= 12)
                    check(br_taken == e, "R10 signed test", br_taken, e);
                else
                    check(br_taken == e, "R8 simple test", br_taken, e);
            end
        end

        // target arithmetic including wrap
        for (int p = 0; p < 5; p++) begin
            for (int o = 0; o < 256; o++) begin
                int e;
                pc_in = 16'(pcs[p]); rel_off = 8'(o);
                step();
                e = (pcs[p] + 2 + ((o > 127) ? o - 256 : o)) & 16'hFFFF;
                check(br_target == 16'(e), "R11 target", br_target, e);
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule